// File: doc/BRIEF.md
# Associative Locking Transaction Buffer

This block keeps track of the shared-memory transactions that a multithreaded processor node has sent out and is still waiting on. Each transaction has two phases: a request goes out to the network, and later a reply comes back with a full data line. The buffer is fully associative. Each of its entries holds a line address, a small state field, a mask of the contexts that are waiting, and the returned line. Every lookup compares the address against all entries in the same cycle.

A request from a context that misses in the buffer claims a free entry and starts one network request. A request to an address that already has a live entry joins that entry, and no second network request goes out. When the reply arrives, its data is locked in the entry. Each waiting context can then read the line once. The entry is released only after the last waiting context has read it. An external coherence invalidation that hits a locked line is held back and recorded, and it is acknowledged when the line is released. A reply therefore cannot be lost between its arrival and the access that uses it. When every entry is busy, a new miss is refused with a retry and no entry is evicted.

Each entry runs a four-state machine:
- FREE goes to REQ_PENDING on allocate.
- REQ_PENDING goes to DATA_LOCKED on fill, or to DATA_LOCKED_INV_PENDING on fill together with an invalidate.
- DATA_LOCKED goes to DATA_LOCKED_INV_PENDING on a deferred invalidate, or back to FREE on the last take.
- DATA_LOCKED_INV_PENDING goes to FREE on the last take, and that take releases the held invalidate.

Top module: `xact_lock_buffer`

## Requirements
- R1: After reset every entry is FREE. An access misses (acc_hit=0), and an invalidate is acknowledged at once (inv_done=1).
- R2: A request whose address matches no live entry, while a FREE entry exists, allocates that entry. In the same cycle it raises net_req_valid with net_req_addr equal to the request address, and req_merged=0 and req_retry=0.
- R3: A request, from any context, to an address that has a live entry raises req_merged=1 in the same cycle, with net_req_valid=0. The requesting context is added to the entry's waiting set.
- R4: An access to an entry that is still in REQ_PENDING misses. A reply whose address matches no REQ_PENDING entry is ignored, so a later request to that address still allocates.
- R5: A reply moves the matching REQ_PENDING entry to DATA_LOCKED and stores the line. An access from a waiting context then gives acc_hit=1 and the stored line on acc_data in the same cycle.
- R6: An access from a context that is not in the entry's waiting set, or that has already read the line, misses.
- R7: The lock holds until every context that requested the address has read the line. After the last read the entry is FREE, and a new request to that address allocates again.
- R8: An invalidate to an address with no live entry, or to an entry in REQ_PENDING with no reply that cycle, gives inv_done=1 in the same cycle.
- R9: An invalidate to a locked entry gives inv_done=0 and leaves the data readable. When the last waiting context reads the line, inv_release_valid=1 and inv_release_addr is set to the line address in that same cycle.
- R10: If an access and an invalidate hit the same entry in one cycle, the access is applied first. If it was the last read, the invalidate is acknowledged at once (inv_done=1, no release). Otherwise the invalidate is deferred.
- R11: With all 16 entries live, a request that misses gives req_retry=1 and net_req_valid=0. Existing entries stay intact: they still merge and still deliver their data.
- R12: A reply and an invalidate to the same entry in the same cycle: the reply is applied first, so the invalidate is deferred (inv_done=0) and is released at the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor context issues a request |
| req_ctx | input | 2 | Requesting context number |
| req_addr | input | 32 | Requested line address |
| req_merged | output | 1 | Request joined a live entry |
| req_retry | output | 1 | Buffer full, request refused |
| net_req_valid | output | 1 | Launch a network request |
| net_req_addr | output | 32 | Address of the launched request |
| rep_valid | input | 1 | Reply from the network |
| rep_addr | input | 32 | Reply line address |
| rep_data | input | 64 | Reply line data |
| acc_valid | input | 1 | Context retries its access |
| acc_ctx | input | 2 | Accessing context |
| acc_addr | input | 32 | Accessed line address |
| acc_hit | output | 1 | Access consumes the line |
| acc_data | output | 64 | Line data on a hit, zero otherwise |
| inv_valid | input | 1 | External invalidate |
| inv_addr | input | 32 | Invalidated line address |
| inv_done | output | 1 | Invalidate acknowledged this cycle |
| inv_release_valid | output | 1 | Held invalidate acknowledged now |
| inv_release_addr | output | 32 | Address of the released invalidate |

## Verification
The assertions check four things on every cycle. Each request has exactly one outcome: launch, merge or retry. No two live entries share an address. A retry happens only when all entries are live. A released invalidate comes only with a hit. Inside each entry they also check that a live entry always has a waiter, that locked data never changes, that REQ_PENDING is left only on a fill, and that a held invalidate is never dropped. Only the bench scenarios can show the value-level ordering: the data delivered to each merged context, which of two same-cycle events wins, and that a refused request evicts nothing.

// File: rtl/txb_pkg.sv
package txb_pkg;
    typedef enum logic [1:0] {
        ST_FREE       = 2'd0,
        ST_REQ_PEND   = 2'd1,
        ST_LOCKED     = 2'd2,
        ST_LOCKED_INV = 2'd3
    } ent_state_e;
endpackage

// File: rtl/txb_cam.sv
// Parallel address compare against every qualified entry.
module txb_cam #(
    parameter int N      = 16,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]         key_i,
    input  logic [N-1:0]              qual_i,
    input  logic [N-1:0][ADDR_W-1:0]  tags_i,
    output logic [N-1:0]              match_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_o[g] = qual_i[g] && (tags_i[g] == key_i);
    end
endmodule

// File: rtl/txb_pick.sv
// Lowest-index free entry selection.
module txb_pick #(
    parameter int N = 16
) (
    input  logic [N-1:0] free_i,
    output logic         any_o,
    output logic [N-1:0] oh_o
);
    always_comb begin
        any_o = 1'b0;
        oh_o  = '0;
        for (int i = 0; i < N; i++) begin
            if (free_i[i] && !any_o) begin
                any_o   = 1'b1;
                oh_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/txb_entry.sv
// One buffer slot: address, line, waiting-context mask and state.
module txb_entry
    import txb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 64,
    parameter int NCTX   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [ADDR_W-1:0] alloc_addr_i,
    input  logic [NCTX-1:0]   join_i,
    input  logic              fill_i,
    input  logic [LINE_W-1:0] fill_data_i,
    input  logic [NCTX-1:0]   take_i,
    input  logic              defer_i,
    output ent_state_e        state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LINE_W-1:0] data_o,
    output logic [NCTX-1:0]   wait_o,
    output logic              last_take_o
);
    ent_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LINE_W-1:0] data_q;
    logic [NCTX-1:0]   wait_q;
    logic              locked;

    assign locked      = state_q[1];
    assign last_take_o = locked && (|take_i) && ((wait_q & ~take_i) == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE:       if (alloc_i) state_d = ST_REQ_PEND;
            ST_REQ_PEND:   if (fill_i)  state_d = defer_i ? ST_LOCKED_INV : ST_LOCKED;
            ST_LOCKED: begin
                if (last_take_o)  state_d = ST_FREE;
                else if (defer_i) state_d = ST_LOCKED_INV;
            end
            ST_LOCKED_INV: if (last_take_o) state_d = ST_FREE;
            default:       state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            wait_q <= '0;
        end else begin
            if (alloc_i && state_q == ST_FREE) begin
                addr_q <= alloc_addr_i;
                wait_q <= join_i;
            end else if (state_q != ST_FREE) begin
                wait_q <= (wait_q & ~take_i) | join_i;
            end
            if (fill_i && state_q == ST_REQ_PEND) data_q <= fill_data_i;
        end
    end

    assign state_o = state_q;
    assign addr_o  = addr_q;
    assign data_o  = data_q;
    assign wait_o  = wait_q;

    // R7: a live entry always has at least one waiting context
    a_r7_live_has_waiter: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FREE) |-> (wait_q != '0));
    // R5: locked line is never overwritten while it stays locked
    a_r5_locked_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(data_q));
    // R4: the pending state is left only when a reply fills it
    a_r4_leave_pending_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_REQ_PEND && state_q != ST_REQ_PEND) |-> $past(fill_i));
    // R9: a held invalidate is kept until the line is freed
    a_r9_inv_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED_INV) |=> (state_q == ST_LOCKED_INV || state_q == ST_FREE));
endmodule

// File: rtl/xact_lock_buffer.sv
module xact_lock_buffer
    import txb_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int ADDR_W  = 32,
    parameter int LINE_W  = 64,
    parameter int NCTX    = 4,
    localparam int IDX_W  = $clog2(NUM_ENT),
    localparam int CTX_W  = $clog2(NCTX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_merged,
    output logic              req_retry,
    output logic              net_req_valid,
    output logic [ADDR_W-1:0] net_req_addr,
    input  logic              rep_valid,
    input  logic [ADDR_W-1:0] rep_addr,
    input  logic [LINE_W-1:0] rep_data,
    input  logic              acc_valid,
    input  logic [CTX_W-1:0]  acc_ctx,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_hit,
    output logic [LINE_W-1:0] acc_data,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              inv_done,
    output logic              inv_release_valid,
    output logic [ADDR_W-1:0] inv_release_addr
);
    ent_state_e                      st_arr [NUM_ENT];
    logic [NUM_ENT-1:0][ADDR_W-1:0]  addr_arr;
    logic [NUM_ENT-1:0][LINE_W-1:0]  data_arr;
    logic [NUM_ENT-1:0][NCTX-1:0]    wait_arr;
    logic [NUM_ENT-1:0]              live, pend, locked, last_take;
    logic [NUM_ENT-1:0]              req_match, fill_match, acc_match, inv_match;
    logic [NUM_ENT-1:0]              free_oh, alloc_v, fill_v, defer_v;
    logic [NUM_ENT-1:0][NCTX-1:0]    join_v, take_v;
    logic                            any_free, req_join, alloc_go;
    logic [IDX_W-1:0]                req_idx, acc_idx;
    logic [NCTX-1:0]                 req_oh, acc_oh;

    function automatic logic [IDX_W-1:0] enc(input logic [NUM_ENT-1:0] v);
        enc = '0;
        for (int i = 0; i < NUM_ENT; i++) if (v[i]) enc = IDX_W'(i);
    endfunction

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_state
        assign live[g]   = (st_arr[g] != ST_FREE);
        assign pend[g]   = (st_arr[g] == ST_REQ_PEND);
        assign locked[g] = st_arr[g][1];
    end

    txb_cam #(.N(NUM_ENT), .ADDR_W(ADDR_W)) u_cam_req
        (.key_i(req_addr), .qual_i(live),   .tags_i(addr_arr), .match_o(req_match));
    txb_cam #(.N(NUM_ENT), .ADDR_W(ADDR_W)) u_cam_fill
        (.key_i(rep_addr), .qual_i(pend),   .tags_i(addr_arr), .match_o(fill_match));
    txb_cam #(.N(NUM_ENT), .ADDR_W(ADDR_W)) u_cam_acc
        (.key_i(acc_addr), .qual_i(locked), .tags_i(addr_arr), .match_o(acc_match));
    txb_cam #(.N(NUM_ENT), .ADDR_W(ADDR_W)) u_cam_inv
        (.key_i(inv_addr), .qual_i(live),   .tags_i(addr_arr), .match_o(inv_match));

    txb_pick #(.N(NUM_ENT)) u_pick (.free_i(~live), .any_o(any_free), .oh_o(free_oh));

    // access path (applied before invalidate and before request merging)
    assign acc_idx  = enc(acc_match);
    assign acc_oh   = NCTX'(1) << acc_ctx;
    assign acc_hit  = acc_valid && (|acc_match) && wait_arr[acc_idx][acc_ctx];
    assign acc_data = acc_hit ? data_arr[acc_idx] : '0;
    assign inv_release_valid = acc_hit && last_take[acc_idx] && (st_arr[acc_idx] == ST_LOCKED_INV);
    assign inv_release_addr  = inv_release_valid ? addr_arr[acc_idx] : '0;

    // request path: a line freed this cycle counts as a miss
    assign req_idx       = enc(req_match);
    assign req_oh        = NCTX'(1) << req_ctx;
    assign req_join      = req_valid && (|req_match) && !last_take[req_idx];
    assign alloc_go      = req_valid && !req_join && any_free;
    assign req_merged    = req_join;
    assign req_retry     = req_valid && !req_join && !any_free;
    assign net_req_valid = alloc_go;
    assign net_req_addr  = alloc_go ? req_addr : '0;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        assign alloc_v[g] = alloc_go && free_oh[g];
        assign join_v[g]  = (alloc_v[g] || (req_join && req_match[g])) ? req_oh : '0;
        assign fill_v[g]  = rep_valid && fill_match[g];
        assign take_v[g]  = (acc_hit && acc_match[g]) ? acc_oh : '0;
        assign defer_v[g] = inv_valid && inv_match[g] && (locked[g] || fill_v[g]) && !last_take[g];

        txb_entry #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .NCTX(NCTX)) u_ent (
            .clk(clk), .rst_n(rst_n),
            .alloc_i(alloc_v[g]), .alloc_addr_i(req_addr), .join_i(join_v[g]),
            .fill_i(fill_v[g]), .fill_data_i(rep_data),
            .take_i(take_v[g]), .defer_i(defer_v[g]),
            .state_o(st_arr[g]), .addr_o(addr_arr[g]), .data_o(data_arr[g]),
            .wait_o(wait_arr[g]), .last_take_o(last_take[g]));
    end

    assign inv_done = inv_valid && !(|defer_v);

    // R2 R3 R11: every request has exactly one outcome
    a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones({net_req_valid, req_merged, req_retry}) == 1));
    // R3: merging keeps at most one live entry per address
    a_r3_unique_line: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(req_match) <= 1);
    // R11: refusal only when every entry is live
    a_r11_retry_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        req_retry |-> (&live));
    // R9: a held invalidate is released only by a consuming access
    a_r9_release_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        inv_release_valid |-> (acc_hit && !$isunknown(inv_release_addr)));
endmodule

// File: tb/tb_xact_lock_buffer.sv
module tb_xact_lock_buffer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, rep_valid, acc_valid, inv_valid;
    logic [1:0]  req_ctx, acc_ctx;
    logic [31:0] req_addr, rep_addr, acc_addr, inv_addr;
    logic [63:0] rep_data;
    logic        req_merged, req_retry, net_req_valid, acc_hit, inv_done, inv_release_valid;
    logic [31:0] net_req_addr, inv_release_addr;
    logic [63:0] acc_data;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 1'b0;

    always #4 clk = ~clk;

    xact_lock_buffer dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ctx(req_ctx), .req_addr(req_addr),
        .req_merged(req_merged), .req_retry(req_retry),
        .net_req_valid(net_req_valid), .net_req_addr(net_req_addr),
        .rep_valid(rep_valid), .rep_addr(rep_addr), .rep_data(rep_data),
        .acc_valid(acc_valid), .acc_ctx(acc_ctx), .acc_addr(acc_addr),
        .acc_hit(acc_hit), .acc_data(acc_data),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_done(inv_done),
        .inv_release_valid(inv_release_valid), .inv_release_addr(inv_release_addr));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        req_valid = 0; rep_valid = 0; acc_valid = 0; inv_valid = 0;
        req_ctx = 0; acc_ctx = 0; req_addr = 0; rep_addr = 0; acc_addr = 0;
        inv_addr = 0; rep_data = 0;
    endtask

    // advance one edge, inputs change 1 ns after it; outputs sampled 1 ns after drive
    task automatic tick();
        @(posedge clk); #1; clr();
    endtask

    task automatic do_req(input logic [1:0] c, input logic [31:0] a);
        req_valid = 1; req_ctx = c; req_addr = a;
    endtask
    task automatic do_rep(input logic [31:0] a, input logic [63:0] d);
        rep_valid = 1; rep_addr = a; rep_data = d;
    endtask
    task automatic do_acc(input logic [1:0] c, input logic [31:0] a);
        acc_valid = 1; acc_ctx = c; acc_addr = a;
    endtask
    task automatic do_inv(input logic [31:0] a);
        inv_valid = 1; inv_addr = a;
    endtask

    task automatic t_reset();
        do_acc(0, 32'h100); do_inv(32'h100); #1;
        chk("R1 acc miss after reset", acc_hit, 0);
        chk("R1 inv ack after reset", inv_done, 1);
        tick();
    endtask

    task automatic t_alloc_merge();
        do_req(0, 32'hA00); #1;
        chk("R2 net req", net_req_valid, 1);
        chk("R2 net addr", net_req_addr, 32'hA00);
        chk("R2 not merged", req_merged, 0);
        tick();
        do_req(2, 32'hA00); #1;
        chk("R3 merged", req_merged, 1);
        chk("R3 no 2nd net req", net_req_valid, 0);
        tick();
        do_acc(0, 32'hA00); #1;
        chk("R4 acc while pending", acc_hit, 0);
        tick();
        do_rep(32'hB00, 64'hDEAD); #1; tick();
        do_rep(32'hA00, 64'h1111_2222_3333_4444); #1; tick();
        do_acc(1, 32'hA00); #1;
        chk("R6 non-waiter misses", acc_hit, 0);
        tick();
        do_acc(0, 32'hA00); #1;
        chk("R5 hit", acc_hit, 1);
        chk("R5 data", acc_data, 64'h1111_2222_3333_4444);
        tick();
        do_acc(0, 32'hA00); #1;
        chk("R6 second read misses", acc_hit, 0);
        tick();
        do_acc(2, 32'hA00); #1;
        chk("R7 lock held for merged ctx", acc_hit, 1);
        chk("R7 merged ctx data", acc_data, 64'h1111_2222_3333_4444);
        tick();
        do_req(1, 32'hA00); #1;
        chk("R7 freed entry reallocates", net_req_valid, 1);
        tick();
        do_req(3, 32'hB00); #1;
        chk("R4 stray reply ignored", net_req_valid, 1);
        tick();
        do_rep(32'hA00, 64'h5); do_acc(1, 32'hA00); #1; tick();
        do_rep(32'hB00, 64'h6); #1; tick();
        do_acc(1, 32'hA00); #1; tick();
        do_acc(3, 32'hB00); #1; tick();
    endtask

    task automatic t_inv_defer();
        do_req(0, 32'hC00); #1; tick();
        do_inv(32'hC00); #1;
        chk("R8 inv on pending acked", inv_done, 1);
        tick();
        do_rep(32'hC00, 64'hCAFE); #1; tick();
        do_inv(32'hC00); #1;
        chk("R9 inv on locked deferred", inv_done, 0);
        chk("R9 no early release", inv_release_valid, 0);
        tick();
        do_acc(0, 32'hC00); #1;
        chk("R9 data kept", acc_data, 64'hCAFE);
        chk("R9 release valid", inv_release_valid, 1);
        chk("R9 release addr", inv_release_addr, 32'hC00);
        tick();
        do_inv(32'hC00); #1;
        chk("R8 inv after free acked", inv_done, 1);
        tick();
    endtask

    task automatic t_same_cycle();
        do_req(0, 32'hE00); #1; tick();
        do_req(1, 32'hE00); #1; tick();
        do_rep(32'hE00, 64'hE1); #1; tick();
        do_acc(0, 32'hE00); do_inv(32'hE00); #1;
        chk("R10 access served", acc_hit, 1);
        chk("R10 not last: deferred", inv_done, 0);
        tick();
        do_acc(1, 32'hE00); #1;
        chk("R10 release at last read", inv_release_valid, 1);
        tick();
        do_req(0, 32'hF00); #1; tick();
        do_rep(32'hF00, 64'hF1); #1; tick();
        do_acc(0, 32'hF00); do_inv(32'hF00); #1;
        chk("R10 last read hit", acc_hit, 1);
        chk("R10 last read: inv acked", inv_done, 1);
        chk("R10 last read: no release", inv_release_valid, 0);
        tick();
    endtask

    task automatic t_reply_inv();
        do_req(0, 32'h700); #1; tick();
        do_rep(32'h700, 64'h77); do_inv(32'h700); #1;
        chk("R12 fill then inv deferred", inv_done, 0);
        tick();
        do_acc(0, 32'h700); #1;
        chk("R12 data", acc_data, 64'h77);
        chk("R12 released", inv_release_valid, 1);
        chk("R12 release addr", inv_release_addr, 32'h700);
        tick();
    endtask

    task automatic t_full();
        int bad = 0;
        for (int i = 0; i < 16; i++) begin
            do_req(0, 32'h1000 + 32'(i) * 32'h40); #1;
            if (net_req_valid !== 1'b1) bad++;
            tick();
        end
        chk("R2 sixteen allocations", bad, 0);
        do_req(1, 32'h9000); #1;
        chk("R11 retry when full", req_retry, 1);
        chk("R11 no net req when full", net_req_valid, 0);
        tick();
        do_req(1, 32'h1000 + 32'h3 * 32'h40); #1;
        chk("R11 merge still works", req_merged, 1);
        tick();
        do_rep(32'h1000 + 32'h5 * 32'h40, 64'h55); #1; tick();
        do_acc(0, 32'h1000 + 32'h5 * 32'h40); #1;
        chk("R11 entry intact", acc_data, 64'h55);
        tick();
        do_req(1, 32'h9000); #1;
        chk("R11 freed slot allocates", net_req_valid, 1);
        tick();
    endtask

    initial begin
        clr();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_alloc_merge();
        t_inv_defer();
        t_same_cycle();
        t_reply_inv();
        t_full();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule